// File: doc/BRIEF.md
# Dual-Channel UART Interrupt Aggregator

This block collects the interrupt requests of two UART channels and presents them as one read-only 32-bit status word, so that a host can find out in a single access which channel wants attention and for what reason. Two views of the same requests share the word. One is a summary bit per channel for fast vectoring. The other is a 3-bit source code per channel that names the highest-priority pending cause.

Level-type sources (line error, receive data, receive timeout, modem change) follow their request lines. The transmit-empty source is captured on a rising edge and is cleared when the host reads that channel's source register. A separate wake interrupt is raised when the device is woken after both channels had been asleep. It is reported on channel 0 and cleared by channel 0's source read. A registered combined interrupt line tells the host that at least one channel is pending.

Top module: `uart_irq_aggregator`

## Requirements
- R1: After reset, a read of the status word returns 0x00000000 and `irq_out` is 0.
- R2: Status bit 0 is 1 exactly when channel 0's source code is non-zero; bit 1 does the same for channel 1.
- R3: Bits 7:2 and bits 31:14 of the status word always read 0.
- R4: Channel 0's source code sits in status bits 10:8 and channel 1's code sits in bits 13:11.
- R5: The code names the most urgent pending source, checked in this order: 1 line error, 2 receive data, 3 receive timeout, 4 transmit empty, 5 modem change, 6 wake; 0 means nothing is pending.
- R6: A level source is pending in the cycle after its request line is sampled high and stays pending while the line stays high, whatever source reads take place; it drops the cycle after the line is sampled low.
- R7: A rising edge on a channel's transmit-empty request latches a pending transmit-empty source. The source stays latched after the line falls and is cleared only by that channel's `stat_rd` strobe. A new rising edge in the same cycle as the strobe wins, and a line held high does not set the source again.
- R8: A `wake_evt` pulse sets the wake source, code 6 on channel 0, only if both `sleep_ch` bits were high in the previous cycle. The wake source has the lowest priority.
- R9: The wake source is cleared by `stat_rd[0]`; `stat_rd[1]` leaves it set.
- R10: When `rd_en` is high, `rd_data` loads the status word on the next clock edge if `rd_addr` is dword index 0x20 (byte offset 0x080), and 0 for any other index. When `rd_en` is low, `rd_data` holds its value.
- R11: `irq_out` equals the OR of the two summary bits, delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_req | input | 2 | Per-channel receive line error request (level) |
| rxd_req | input | 2 | Per-channel receive data ready request (level) |
| rxto_req | input | 2 | Per-channel receive timeout request (level) |
| txe_req | input | 2 | Per-channel transmit holding empty request (edge-captured) |
| msr_req | input | 2 | Per-channel modem status change request (level) |
| stat_rd | input | 2 | Per-channel strobe: host read the channel's source register |
| sleep_ch | input | 2 | Per-channel sleep indication |
| wake_evt | input | 1 | Device wake event pulse |
| rd_en | input | 1 | Register read enable |
| rd_addr | input | 6 | Dword register index |
| rd_data | output | 32 | Registered read data |
| irq_out | output | 1 | Registered combined interrupt |

## Verification
The assertions assume that `stat_rd` and `wake_evt` are single-cycle pulses sampled on the clock, and that `sleep_ch` has settled for at least one edge before a wake pulse is judged. The stimulus changes every input on the falling edge. It keeps each strobe high for exactly one cycle and holds both sleep bits for two edges before it pulses the wake event. Reads are issued only after the request changes they observe have passed through the pending registers.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  localparam int CODE_W = 3;

  typedef logic [CODE_W-1:0] irq_code_t;

  localparam irq_code_t CODE_NONE    = 3'd0;
  localparam irq_code_t CODE_LINE    = 3'd1;
  localparam irq_code_t CODE_RXDATA  = 3'd2;
  localparam irq_code_t CODE_RXTMO   = 3'd3;
  localparam irq_code_t CODE_TXEMPTY = 3'd4;
  localparam irq_code_t CODE_MODEM   = 3'd5;
  localparam irq_code_t CODE_WAKE    = 3'd6;

  typedef struct packed {
    logic line;
    logic rxdata;
    logic rxtmo;
    logic txempty;
    logic modem;
    logic wake;
  } irq_pend_t;

  // Most urgent pending source wins.
  function automatic irq_code_t irq_pick(input irq_pend_t p);
    irq_code_t c;
    if (p.line)         c = CODE_LINE;
    else if (p.rxdata)  c = CODE_RXDATA;
    else if (p.rxtmo)   c = CODE_RXTMO;
    else if (p.txempty) c = CODE_TXEMPTY;
    else if (p.modem)   c = CODE_MODEM;
    else if (p.wake)    c = CODE_WAKE;
    else                c = CODE_NONE;
    return c;
  endfunction

endpackage

// File: rtl/irq_src_chan.sv
module irq_src_chan
  import irq_agg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      line_req,
  input  logic      rxd_req,
  input  logic      rxto_req,
  input  logic      txe_req,
  input  logic      msr_req,
  input  logic      stat_rd,
  input  logic      wake_pend,
  output irq_code_t code,
  output logic      summary
);

  localparam int LVL_N = 4;

  logic [LVL_N-1:0] lvl_q, lvl_d;
  logic             txe_line_q, txe_line_d;
  logic             txe_pend_q, txe_pend_d;
  logic             txe_rise;
  irq_pend_t        pend;

  // next state
  always_comb begin
    lvl_d      = {line_req, rxd_req, rxto_req, msr_req};
    txe_line_d = txe_req;
    txe_rise   = txe_req & ~txe_line_q;
    txe_pend_d = txe_pend_q;
    if (stat_rd)  txe_pend_d = 1'b0;
    if (txe_rise) txe_pend_d = 1'b1;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q      <= '0;
      txe_line_q <= 1'b0;
      txe_pend_q <= 1'b0;
    end else begin
      lvl_q      <= lvl_d;
      txe_line_q <= txe_line_d;
      txe_pend_q <= txe_pend_d;
    end
  end

  always_comb begin
    pend.line    = lvl_q[3];
    pend.rxdata  = lvl_q[2];
    pend.rxtmo   = lvl_q[1];
    pend.modem   = lvl_q[0];
    pend.txempty = txe_pend_q;
    pend.wake    = wake_pend;
    code         = irq_pick(pend);
    summary      = (code != CODE_NONE);
  end

  assert_txe_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (txe_req && !txe_line_q) |=> (code != CODE_NONE));

  assert_txe_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !(txe_req && !txe_line_q)) |=> !txe_pend_q);

  assert_level_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rxd_req |=> (code == CODE_LINE || code == CODE_RXDATA));

  assert_code_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    code != 3'd7);

endmodule

// File: rtl/irq_wake_unit.sv
module irq_wake_unit #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] sleep_ch,
  input  logic           wake_evt,
  input  logic           clr,
  output logic           wake_pend
);

  logic [NCH-1:0] sleep_q;
  logic           wake_q, wake_d;
  logic           wake_set;

  always_comb begin
    wake_set = wake_evt & (&sleep_q);
    wake_d   = wake_q;
    if (clr)      wake_d = 1'b0;
    if (wake_set) wake_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleep_q <= '0;
      wake_q  <= 1'b0;
    end else begin
      sleep_q <= sleep_ch;
      wake_q  <= wake_d;
    end
  end

  assign wake_pend = wake_q;

  assert_wake_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_evt && (&sleep_q)) |=> wake_pend);

  assert_wake_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !(wake_evt && (&sleep_q))) |=> !wake_pend);

endmodule

// File: rtl/irq_word_port.sv
module irq_word_port
  import irq_agg_pkg::*;
#(
  parameter int                NCH       = 2,
  parameter int                ADDR_W    = 6,
  parameter logic [ADDR_W-1:0] WORD_IDX  = 6'h20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NCH*CODE_W-1:0] codes,
  input  logic [NCH-1:0]      summary,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [31:0]         rd_data,
  output logic                irq_out
);

  localparam int CODE_LO = 8;
  localparam int RES_LO  = CODE_LO + NCH*CODE_W;

  logic [31:0] word;
  logic [31:0] rd_d;
  logic        irq_d;

  always_comb begin
    word = '0;
    word[NCH-1:0] = summary;
    word[RES_LO-1:CODE_LO] = codes;
  end

  always_comb begin
    rd_d = rd_data;
    if (rd_en) rd_d = (rd_addr == WORD_IDX) ? word : 32'h0;
    irq_d = |summary;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
      irq_out <= 1'b0;
    end else begin
      rd_data <= rd_d;
      irq_out <= irq_d;
    end
  end

  assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[31:RES_LO] == '0) && (rd_data[7:NCH] == '0));

  assert_irq_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (|summary) |=> irq_out);

  assert_irq_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(|summary) |=> !irq_out);

  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

endmodule

// File: rtl/uart_irq_aggregator.sv
module uart_irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    line_req,
  input  logic [NCH-1:0]    rxd_req,
  input  logic [NCH-1:0]    rxto_req,
  input  logic [NCH-1:0]    txe_req,
  input  logic [NCH-1:0]    msr_req,
  input  logic [NCH-1:0]    stat_rd,
  input  logic [NCH-1:0]    sleep_ch,
  input  logic              wake_evt,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic              irq_out
);

  logic [NCH*CODE_W-1:0] codes;
  logic [NCH-1:0]        summary;
  logic                  wake_pend;

  irq_wake_unit #(.NCH(NCH)) u_wake (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep_ch  (sleep_ch),
    .wake_evt  (wake_evt),
    .clr       (stat_rd[0]),
    .wake_pend (wake_pend)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    logic      chan_wake;
    irq_code_t chan_code;
    if (i == 0) begin : g_wake_on
      assign chan_wake = wake_pend;
    end else begin : g_wake_off
      assign chan_wake = 1'b0;
    end
    irq_src_chan u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_req  (line_req[i]),
      .rxd_req   (rxd_req[i]),
      .rxto_req  (rxto_req[i]),
      .txe_req   (txe_req[i]),
      .msr_req   (msr_req[i]),
      .stat_rd   (stat_rd[i]),
      .wake_pend (chan_wake),
      .code      (chan_code),
      .summary   (summary[i])
    );
    assign codes[i*CODE_W +: CODE_W] = chan_code;
  end

  irq_word_port #(.NCH(NCH), .ADDR_W(ADDR_W)) u_port (
    .clk     (clk),
    .rst_n   (rst_n),
    .codes   (codes),
    .summary (summary),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .irq_out (irq_out)
  );

  assert_summary_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    summary[1] |-> (codes[2*CODE_W-1:CODE_W] != CODE_NONE));

endmodule

// File: tb/sim_uart_irq_aggregator.sv
module sim_uart_irq_aggregator;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  line_req, rxd_req, rxto_req, txe_req, msr_req, stat_rd, sleep_ch;
  logic        wake_evt, rd_en;
  logic [5:0]  rd_addr;
  logic [31:0] rd_data;
  logic        irq_out;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_irq_aggregator u0 (
    .clk(clk), .rst_n(rst_n), .line_req(line_req), .rxd_req(rxd_req),
    .rxto_req(rxto_req), .txe_req(txe_req), .msr_req(msr_req),
    .stat_rd(stat_rd), .sleep_ch(sleep_ch), .wake_evt(wake_evt),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq_out(irq_out)
  );

  typedef struct {
    logic [31:0] data;
    string       tag;
  } exp_t;

  exp_t sb_q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // expected status word from the two codes (R2, R3, R4)
  function automatic logic [31:0] word(input logic [2:0] c0, input logic [2:0] c1);
    return {18'h0, c1, c0, 6'h0, (c1 != 3'd0), (c0 != 3'd0)};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_at(input logic [5:0] a, input logic [31:0] e, input string tag);
    exp_t it;
    it.data = e;
    it.tag  = tag;
    rd_en   = 1'b1;
    rd_addr = a;
    sb_q.push_back(it);
    @(negedge clk);
    rd_en   = 1'b0;
  endtask

  task automatic rd_exp(input logic [31:0] e, input string tag);
    rd_at(6'h20, e, tag);
  endtask

  task automatic pulse_rd(input int ch);
    stat_rd[ch] = 1'b1;
    tick(1);
    stat_rd = '0;
  endtask

  // monitor: pop and compare one item per read
  initial begin
    forever begin
      @(posedge clk);
      if (rd_en === 1'b1) begin
        @(negedge clk);
        if (sb_q.size() == 0) begin
          chk(32'hx, 32'h0, "R10 unexpected read");
        end else begin
          exp_t it;
          it = sb_q.pop_front();
          chk(rd_data, it.data, it.tag);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    line_req = '0; rxd_req = '0; rxto_req = '0; txe_req = '0; msr_req = '0;
    stat_rd = '0; sleep_ch = '0; wake_evt = 1'b0; rd_en = 1'b0; rd_addr = '0;
    tick(3);
    rst_n = 1'b1;
    tick(1);

    rd_exp(32'h0, "R1 reset word");
    chk({31'h0, irq_out}, 32'h0, "R1 reset irq_out");

    // priority ladder on channel 0 (R5)
    msr_req[0] = 1'b1; tick(1);
    rd_exp(word(3'd5, 3'd0), "R5 modem code / R2 / R4 ch0 field");
    chk({31'h0, irq_out}, 32'h1, "R11 irq_out raised");
    rxto_req[0] = 1'b1; tick(1);
    rd_exp(word(3'd3, 3'd0), "R5 rx timeout over modem");
    rxd_req[0] = 1'b1; tick(1);
    rd_exp(word(3'd2, 3'd0), "R5 rx data over timeout");
    line_req[0] = 1'b1; tick(1);
    rd_exp(word(3'd1, 3'd0), "R5 line error highest");
    line_req[0] = 1'b0; tick(1);
    rd_exp(word(3'd2, 3'd0), "R6 line error dropped");

    // level source ignores reads (R6)
    pulse_rd(0);
    rd_exp(word(3'd2, 3'd0), "R6 level survives source read");
    rxd_req[0] = 1'b0; rxto_req[0] = 1'b0; msr_req[0] = 1'b0; tick(1);
    rd_exp(32'h0, "R6 all lines low");
    chk({31'h0, irq_out}, 32'h0, "R11 irq_out dropped");

    // transmit empty latch on channel 1 (R7)
    txe_req[1] = 1'b1; tick(1);
    rd_exp(word(3'd0, 3'd4), "R7 tx empty / R4 ch1 field");
    txe_req[1] = 1'b0; tick(1);
    rd_exp(word(3'd0, 3'd4), "R7 latched after line falls");
    pulse_rd(0);
    rd_exp(word(3'd0, 3'd4), "R7 other channel read ignored");
    pulse_rd(1);
    rd_exp(32'h0, "R7 cleared by own read");
    txe_req[1] = 1'b1; stat_rd[1] = 1'b1; tick(1); stat_rd = '0;
    rd_exp(word(3'd0, 3'd4), "R7 new edge wins over read");
    pulse_rd(1);
    tick(1);
    rd_exp(32'h0, "R7 held line does not retrigger");
    txe_req[1] = 1'b0;

    // both channels, address decode, hold (R10)
    rxd_req[0] = 1'b1; line_req[1] = 1'b1; tick(1);
    rd_exp(word(3'd2, 3'd1), "R4 both channels");
    tick(3);
    chk(rd_data, word(3'd2, 3'd1), "R10 hold without rd_en");
    rd_at(6'h21, 32'h0, "R10 other index reads zero");
    rxd_req[0] = 1'b0; line_req[1] = 1'b0; tick(1);

    // wake (R8, R9)
    sleep_ch = 2'b01; tick(2);
    wake_evt = 1'b1; tick(1); wake_evt = 1'b0;
    rd_exp(32'h0, "R8 one channel asleep no wake");
    sleep_ch = 2'b11; tick(2);
    wake_evt = 1'b1; tick(1); wake_evt = 1'b0; sleep_ch = 2'b00;
    rd_exp(word(3'd6, 3'd0), "R8 wake code on ch0");
    chk({31'h0, irq_out}, 32'h1, "R11 irq_out on wake");
    msr_req[0] = 1'b1; tick(1);
    rd_exp(word(3'd5, 3'd0), "R8 wake lowest priority");
    msr_req[0] = 1'b0; tick(1);
    rd_exp(word(3'd6, 3'd0), "R8 wake still pending");
    pulse_rd(1);
    rd_exp(word(3'd6, 3'd0), "R9 ch1 read keeps wake");
    pulse_rd(0);
    rd_exp(32'h0, "R9 ch0 read clears wake");

    tick(3);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule